// File: doc/BRIEF.md
# Sum-of-Products Key Sequence Evaluator

This block is the arithmetic sequencer behind a calculator keypad that uses multiply-before-add precedence without parentheses keys. A decoded key token arrives with a one-cycle valid strobe; the block keeps a closed partial sum, an open product term, an entry register and a single user memory, and settles precedence as the keys arrive. A product term stays open while multiply keys keep extending it. An add key closes it into the partial sum, and equals closes everything and shows the total.

Operands are signed binary integers of a parameterised width (32 bits by default). Digit keys build the entry in decimal. A result that leaves the signed range raises a sticky overflow flag. Multiplication runs on an iterative shift-and-add unit; while it runs the block reports busy and drops any token offered.

Top module: `sop_calc`

## Requirements
- R1: After reset the display reads 0 and both busy and overflow are low.
- R2: Digit tokens use codes 0 to 9. Each digit makes the entry ten times the old entry plus the digit, and the display shows the entry. The first digit after an operator, equals, clear or recall starts a new entry that equals that digit.
- R3: Multiply (code 10) binds tighter than add (code 11). The keys 2, x, 3, +, 4, x, 5, equals (code 12) display 26.
- R4: Equals shows the sum of all pending terms, and that result acts as an operand, so equals followed by an operator continues from it.
- R5: Store (code 13) copies the displayed value into the single memory and leaves the display unchanged. Recall (code 14) puts the memory into the entry as if it had been typed, and the display shows it. The keys 2, +, 3, =, STO, 4, +, 5, =, x, RCL, = display 45.
- R6: An operator that follows another operator with no operand between them replaces it, and no operand is applied twice.
- R7: Clear (code 15) sets the display to 0 and clears the partial sum, the product term, the entry, the pending operator and the overflow flag. The memory keeps its value.
- R8: Any entry, product, partial sum or total outside the signed W-bit range sets the overflow flag, which stays set through later keys until clear.
- R9: A multiply key or an equals key that closes a product term with a fresh operand raises busy in the next cycle. Busy stays high for no more than W+1 cycles. Tokens offered while busy is high are ignored.
- R10: After a multiply key the display shows the current product term. After an add key it shows the partial sum including that term.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tok_valid | input | 1 | Token strobe, one cycle per key |
| tok_code | input | 4 | Key code: 0-9 digit, 10 multiply, 11 add, 12 equals, 13 store, 14 recall, 15 clear |
| disp_o | output | W | Displayed value, signed |
| busy_o | output | 1 | Multiplication in progress; tokens are dropped |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The assertions take for granted that one token is presented per strobe and that tok_code holds a defined 4-bit value whenever tok_valid is high. They also assume the display is only meaningful once busy has fallen. The stimulus sends each key as a single-cycle strobe and waits for busy to drop before the next key. The one exception is the scenario that deliberately offers a digit during a multiplication to show that it is dropped.

// File: rtl/sop_pkg.sv
package sop_pkg;

  typedef logic signed [63:0] wide_t;

  localparam logic [3:0] K_MUL = 4'd10;
  localparam logic [3:0] K_ADD = 4'd11;
  localparam logic [3:0] K_EQ  = 4'd12;
  localparam logic [3:0] K_STO = 4'd13;
  localparam logic [3:0] K_RCL = 4'd14;
  localparam logic [3:0] K_CLR = 4'd15;

  typedef enum logic [1:0] {OP_NONE, OP_MUL, OP_ADD} op_e;

  // decimal shift of the entry: e*10 + d
  function automatic wide_t f_append(wide_t e, logic [3:0] d);
    return (e <<< 3) + (e <<< 1) + $signed({60'd0, d});
  endfunction

  // true when v lies inside the signed range of width w
  function automatic logic f_fits(wide_t v, int unsigned w);
    wide_t lim;
    lim = 64'sd1 <<< (w - 1);
    return (v < lim) && (v >= -lim);
  endfunction

endpackage

// File: rtl/sop_entry.sv
module sop_entry
  import sop_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                dig_i,
  input  logic [3:0]          dig_val_i,
  input  logic                load_i,
  input  logic signed [W-1:0] load_val_i,
  input  logic                consume_i,
  output logic signed [W-1:0] entry_o,
  output logic                ready_o,
  output logic                fresh_o,
  output logic                ovf_o
);

  logic signed [W-1:0] ent_q;
  logic                fresh_q;
  logic                ready_q;
  wide_t               app_w;

  assign app_w   = f_append(wide_t'(ent_q), dig_val_i);
  assign ovf_o   = dig_i && !fresh_q && !f_fits(app_w, W);
  assign entry_o = ent_q;
  assign ready_o = ready_q;
  assign fresh_o = fresh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q   <= '0;
      fresh_q <= 1'b1;
      ready_q <= 1'b0;
    end else if (clr_i) begin
      ent_q   <= '0;
      fresh_q <= 1'b1;
      ready_q <= 1'b0;
    end else if (load_i) begin
      ent_q   <= load_val_i;
      fresh_q <= 1'b1;
      ready_q <= 1'b1;
    end else if (consume_i) begin
      fresh_q <= 1'b1;
      ready_q <= 1'b0;
    end else if (dig_i) begin
      ent_q   <= fresh_q ? $signed({{(W-4){1'b0}}, dig_val_i}) : app_w[W-1:0];
      fresh_q <= 1'b0;
      ready_q <= 1'b1;
    end
  end

endmodule

// File: rtl/sop_mul.sv
module sop_mul #(
  parameter int unsigned W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic signed [W-1:0] a_i,
  input  logic signed [W-1:0] b_i,
  output logic                busy_o,
  output logic                done_o,
  output logic signed [W-1:0] prod_o,
  output logic                ovf_o
);

  localparam int unsigned CW = $clog2(W + 1);
  localparam logic [2*W-1:0] LIM = {{W{1'b0}}, 1'b1, {(W-1){1'b0}}};

  logic [W-1:0]   mb_q;
  logic [2*W-1:0] mc_q;
  logic [2*W-1:0] acc_q;
  logic [2*W-1:0] acc_nx;
  logic           neg_q;
  logic [CW-1:0]  cnt_q;
  logic           busy_q;
  logic           done_q;
  logic           ovf_q;
  logic signed [W-1:0] prod_q;
  logic [W-1:0]   mag_a;
  logic [W-1:0]   mag_b;
  logic           last_w;
  logic           ovf_w;

  assign mag_a  = a_i[W-1] ? W'(-a_i) : W'(a_i);
  assign mag_b  = b_i[W-1] ? W'(-b_i) : W'(b_i);
  assign acc_nx = mb_q[0] ? acc_q + mc_q : acc_q;
  assign last_w = (cnt_q == CW'(W - 1));
  assign ovf_w  = neg_q ? (acc_nx > LIM) : (acc_nx >= LIM);

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign prod_o = prod_q;
  assign ovf_o  = ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mb_q   <= '0;
      mc_q   <= '0;
      acc_q  <= '0;
      neg_q  <= 1'b0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
      prod_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        mb_q   <= mag_b;
        mc_q   <= {{W{1'b0}}, mag_a};
        acc_q  <= '0;
        neg_q  <= a_i[W-1] ^ b_i[W-1];
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        acc_q <= acc_nx;
        mc_q  <= mc_q << 1;
        mb_q  <= mb_q >> 1;
        cnt_q <= cnt_q + 1'b1;
        if (last_w) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          ovf_q  <= ovf_w;
          prod_q <= neg_q ? -$signed(acc_nx[W-1:0]) : $signed(acc_nx[W-1:0]);
        end
      end
    end
  end

endmodule

// File: rtl/sop_calc.sv
module sop_calc
  import sop_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tok_valid,
  input  logic [3:0]          tok_code,
  output logic signed [W-1:0] disp_o,
  output logic                busy_o,
  output logic                ovf_o
);

  logic signed [W-1:0] sum_q, term_q, mem_q, disp_q;
  logic                show_ent_q;
  op_e                 op_q;
  logic [3:0]          pend_q;
  logic                ovf_q;

  logic signed [W-1:0] entry;
  logic                ent_ready, ent_fresh, ent_ovf;
  logic                mul_busy, mul_done, mul_ovf;
  logic signed [W-1:0] mul_prod;

  // decoded events, named for the checker
  logic acc_tok, is_dig, is_op, is_sto, is_rcl, is_clr;
  logic need_mul, fin;
  logic [3:0] fin_key;

  logic signed [W-1:0] t_nx, s_nx, tot;
  wide_t               s_wide, tot_wide;
  logic                s_ovf, tot_ovf, ovf_set;
  logic                ent_load, ent_consume;
  logic signed [W-1:0] ent_load_val;

  assign busy_o  = mul_busy | mul_done;
  assign acc_tok = tok_valid & ~busy_o;
  assign is_dig  = acc_tok && (tok_code <= 4'd9);
  assign is_op   = acc_tok && ((tok_code == K_MUL) || (tok_code == K_ADD) || (tok_code == K_EQ));
  assign is_sto  = acc_tok && (tok_code == K_STO);
  assign is_rcl  = acc_tok && (tok_code == K_RCL);
  assign is_clr  = acc_tok && (tok_code == K_CLR);

  assign need_mul = is_op && ent_ready && (op_q == OP_MUL);
  assign fin      = (is_op && !need_mul) || mul_done;
  assign fin_key  = mul_done ? pend_q : tok_code;

  // close the open term with the operand, then form the running total
  always_comb begin
    t_nx   = term_q;
    s_wide = wide_t'(sum_q);
    s_ovf  = 1'b0;
    if (mul_done) begin
      t_nx = mul_prod;
    end else if (ent_ready) begin
      t_nx = entry;
      if (op_q == OP_ADD) begin
        s_wide = wide_t'(sum_q) + wide_t'(term_q);
        s_ovf  = !f_fits(s_wide, W);
      end
    end
    s_nx     = s_wide[W-1:0];
    tot_wide = wide_t'(s_nx) + wide_t'(t_nx);
    tot_ovf  = !f_fits(tot_wide, W);
    tot      = tot_wide[W-1:0];
  end

  assign ovf_set = (is_dig && ent_ovf) || (mul_done && mul_ovf) ||
                   (fin && s_ovf) || (fin && (fin_key != K_MUL) && tot_ovf);

  assign ent_load     = is_rcl || (fin && (fin_key == K_EQ));
  assign ent_load_val = is_rcl ? mem_q : tot;
  assign ent_consume  = need_mul || (fin && !mul_done);

  assign disp_o = show_ent_q ? entry : disp_q;
  assign ovf_o  = ovf_q;

  sop_entry #(.W(W)) u_entry (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (is_clr),
    .dig_i      (is_dig),
    .dig_val_i  (tok_code),
    .load_i     (ent_load),
    .load_val_i (ent_load_val),
    .consume_i  (ent_consume),
    .entry_o    (entry),
    .ready_o    (ent_ready),
    .fresh_o    (ent_fresh),
    .ovf_o      (ent_ovf)
  );

  sop_mul #(.W(W)) u_mul (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (need_mul),
    .a_i     (term_q),
    .b_i     (entry),
    .busy_o  (mul_busy),
    .done_o  (mul_done),
    .prod_o  (mul_prod),
    .ovf_o   (mul_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q      <= '0;
      term_q     <= '0;
      mem_q      <= '0;
      disp_q     <= '0;
      show_ent_q <= 1'b0;
      op_q       <= OP_NONE;
      pend_q     <= K_EQ;
      ovf_q      <= 1'b0;
    end else if (is_clr) begin
      sum_q      <= '0;
      term_q     <= '0;
      disp_q     <= '0;
      show_ent_q <= 1'b0;
      op_q       <= OP_NONE;
      ovf_q      <= 1'b0;
    end else begin
      if (ovf_set) ovf_q <= 1'b1;
      if (need_mul) pend_q <= tok_code;
      if (is_sto) mem_q <= disp_o;
      if (is_dig || is_rcl) show_ent_q <= 1'b1;
      if (fin) begin
        show_ent_q <= 1'b0;
        case (fin_key)
          K_MUL: begin
            term_q <= t_nx;
            sum_q  <= s_nx;
            op_q   <= OP_MUL;
            disp_q <= t_nx;
          end
          K_ADD: begin
            term_q <= t_nx;
            sum_q  <= s_nx;
            op_q   <= OP_ADD;
            disp_q <= tot;
          end
          default: begin
            term_q <= '0;
            sum_q  <= '0;
            op_q   <= OP_NONE;
            disp_q <= tot;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/sop_calc_chk.sv
module sop_calc_chk #(
  parameter int unsigned W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                is_dig,
  input logic                is_op,
  input logic                is_sto,
  input logic                is_rcl,
  input logic                is_clr,
  input logic                need_mul,
  input logic                mul_done,
  input logic                busy_o,
  input logic                ovf_o,
  input logic signed [W-1:0] disp_o,
  input logic signed [W-1:0] entry,
  input logic signed [W-1:0] mem_q
);

  int unsigned busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_run <= 0;
    else if (busy_o) busy_run <= busy_run + 1;
    else busy_run <= 0;
  end

  // R2: a digit key leaves the entry on the display
  assert_digit_shown_R2: assert property (@(posedge clk) disable iff (!rst_n)
    is_dig |=> (disp_o == entry));

  // R5: store copies the display and keeps it
  assert_store_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_sto |=> ($stable(disp_o) && (mem_q == $past(disp_o))));

  // R5: recall shows the memory
  assert_recall_shows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_rcl |=> (disp_o == $past(mem_q)));

  // R7: clear zeroes display and flag
  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    is_clr |=> ((disp_o == '0) && !ovf_o));

  // R8: overflow is sticky until clear
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !is_clr) |=> ovf_o);

  // R9: a started product makes the block busy
  assert_mul_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    need_mul |=> busy_o);

  // R9: while busy the display and memory hold
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !mul_done) |=> ($stable(disp_o) && $stable(mem_q)));

  // R9: busy window bounded
  assert_busy_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= W + 1);

  // R9: no token is decoded while busy; decodes are exclusive
  assert_decode_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({is_dig, is_op, is_sto, is_rcl, is_clr}) && !(busy_o && (is_dig || is_op || is_sto || is_rcl || is_clr)));

endmodule

bind sop_calc sop_calc_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .is_dig   (is_dig),
  .is_op    (is_op),
  .is_sto   (is_sto),
  .is_rcl   (is_rcl),
  .is_clr   (is_clr),
  .need_mul (need_mul),
  .mul_done (mul_done),
  .busy_o   (busy_o),
  .ovf_o    (ovf_o),
  .disp_o   (disp_o),
  .entry    (entry),
  .mem_q    (mem_q)
);

// File: tb/tb_sop_calc.sv
module tb_sop_calc;

  localparam int unsigned W = 32;
  localparam logic [3:0] MUL = 4'd10, ADD = 4'd11, EQ = 4'd12,
                         STO = 4'd13, RCL = 4'd14, CLR = 4'd15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tok_valid = 1'b0;
  logic [3:0] tok_code = 4'd0;
  logic signed [W-1:0] disp_o;
  logic busy_o, ovf_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sop_calc #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_code(tok_code),
    .disp_o(disp_o), .busy_o(busy_o), .ovf_o(ovf_o)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic key(input logic [3:0] c);
    @(negedge clk);
    tok_valid = 1'b1;
    tok_code  = c;
    @(negedge clk);
    tok_valid = 1'b0;
    for (int n = 0; n < 200 && busy_o; n++) @(negedge clk);
  endtask

  task automatic num(input longint v);
    longint p = 1;
    while (p * 10 <= v) p = p * 10;
    while (p > 0) begin
      key(4'((v / p) % 10));
      p = p / 10;
    end
  endtask

  task automatic t_reset();
    chk("R1 display", disp_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 ovf", ovf_o, 0);
  endtask

  task automatic t_digits();
    key(CLR);
    key(4'd1); chk("R2 first digit", disp_o, 1);
    key(4'd2); chk("R2 second digit", disp_o, 12);
    key(4'd3); chk("R2 third digit", disp_o, 123);
  endtask

  task automatic t_precedence();
    key(CLR);
    key(4'd2); key(MUL);
    chk("R10 term after x", disp_o, 2);
    key(4'd3); key(ADD);
    chk("R10 sum after +", disp_o, 2 * 3);
    key(4'd4); key(MUL);
    chk("R10 new term", disp_o, 4);
    key(4'd5); key(EQ);
    chk("R3 2x3+4x5", disp_o, 2 * 3 + 4 * 5);
    key(MUL); key(4'd2); key(EQ);
    chk("R4 chain from result", disp_o, (2 * 3 + 4 * 5) * 2);
    key(4'd7);
    chk("R2 fresh after equals", disp_o, 7);
  endtask

  task automatic t_memory();
    key(CLR);
    key(4'd2); key(ADD); key(4'd3); key(EQ);
    chk("R4 2+3", disp_o, 5);
    key(STO);
    chk("R5 store keeps display", disp_o, 5);
    key(4'd4); key(ADD); key(4'd5); key(EQ);
    chk("R4 4+5", disp_o, 9);
    key(MUL); key(RCL);
    chk("R5 recall shows memory", disp_o, 5);
    key(EQ);
    chk("R5 product of sums", disp_o, (2 + 3) * (4 + 5));
  endtask

  task automatic t_replace();
    key(CLR);
    key(4'd2); key(ADD); key(MUL); key(4'd3); key(EQ);
    chk("R6 add replaced by mul", disp_o, 2 * 3);
    key(CLR);
    key(4'd2); key(MUL); key(ADD); key(4'd3); key(EQ);
    chk("R6 mul replaced by add", disp_o, 2 + 3);
    key(CLR);
    key(4'd4); key(ADD); key(ADD); key(4'd1); key(EQ);
    chk("R6 double add", disp_o, 4 + 1);
  endtask

  task automatic t_clear();
    key(CLR);
    key(4'd9); key(ADD); key(4'd8); key(MUL);
    key(CLR);
    chk("R7 display zero", disp_o, 0);
    key(4'd4); key(EQ);
    chk("R7 sum and term cleared", disp_o, 4);
    key(RCL);
    chk("R7 memory kept", disp_o, 5);
  endtask

  task automatic t_overflow();
    key(CLR);
    num(64'd2147483647);
    chk("R8 max entry", disp_o, 2147483647);
    chk("R8 max entry no ovf", ovf_o, 0);
    key(CLR);
    num(64'd2147483648);
    chk("R8 entry overflow", ovf_o, 1);
    key(CLR);
    chk("R7 clear drops ovf", ovf_o, 0);
    num(64'd65536); key(MUL); num(64'd65536); key(EQ);
    chk("R8 product overflow", ovf_o, 1);
    key(CLR);
    key(4'd1); key(ADD); key(4'd1); key(EQ);
    chk("R8 no ovf for small sum", ovf_o, 0);
    key(CLR);
    num(64'd2147483647); key(ADD); key(4'd1); key(EQ);
    chk("R8 sum overflow", ovf_o, 1);
    key(4'd3); key(ADD); key(4'd2); key(EQ);
    chk("R8 flag sticky", ovf_o, 1);
    key(CLR);
  endtask

  task automatic t_busy();
    int cnt = 0;
    key(CLR);
    key(4'd3); key(MUL); key(4'd4);
    @(negedge clk);
    tok_valid = 1'b1; tok_code = MUL;
    @(negedge clk);
    chk("R9 busy raised", busy_o, 1);
    tok_code = 4'd9;
    @(negedge clk);
    tok_valid = 1'b0;
    cnt = 2;
    while (busy_o && cnt < 200) begin @(negedge clk); cnt++; end
    chk("R9 busy bounded", (cnt - 1 <= W + 1) ? 1 : 0, 1);
    chk("R9 digit while busy ignored", disp_o, 3 * 4);
    key(4'd5); key(EQ);
    chk("R9 continue after busy", disp_o, 3 * 4 * 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_digits();
    t_precedence();
    t_memory();
    t_replace();
    t_clear();
    t_overflow();
    t_busy();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule